// File: doc/BRIEF.md
# Synchronous Slave-FIFO Burst Reader

This block sits in an FPGA and acts as the master of a synchronous slave-FIFO parallel bus. On the other side of the bus is a USB bridge device that buffers packets from the host. The block drives the bus's active-low strobes. It watches the bridge's buffer-status flag and pulls words out of the bridge one per bus clock. Each received word is presented on a simple valid/data stream.

A burst begins when `start` is pulsed. Chip select goes low, and the controller waits until it sees the flag high through its delay pipeline. It then drops output enable for one cycle before it drops the read strobe. The read strobe stays low for as many cycles as there are words to move. It is released when the delayed flag reports the buffer empty, or when a full packet's worth of reads has been issued. Words still in the read pipeline are accepted during a drain phase. The burst ends with a one-cycle done pulse, and the count output then shows how many valid words were captured, so a short packet shows up as a count below a full packet.

The returned-data latency `LAT` (2 or 3 clocks) and the flag delay `FLAG_DLY` are parameters. Read cycles issued while the bridge reported empty return no data, and none of them reaches the output stream.

Top module: `slave_fifo_reader`

## Requirements
- R1: During and right after a synchronous active-high reset, all five strobes are high, `outValid` is 0 and `burstDone` is 0.
- R2: The write strobe `wrN` and the packet-end strobe `pktEndN` stay high at all times.
- R3: `csN` is low from the cycle after an accepted `start` until the done cycle, and low whenever `oeN` or `rdN` is low; the block sits with `csN` high while idle.
- R4: `rdN` never goes low before the delayed flag has been seen high, and `oeN` is low in exactly the one cycle before `rdN` first goes low, with `oeN` high in the cycle before that.
- R5: When the flag goes low (empty), `rdN` returns high after exactly `FLAG_DLY`+1 read cycles that were issued with the flag low.
- R6: A word that is read in cycle c (`rdN` low and flag high in cycle c) appears on `outData` with `outValid` high in cycle c+`LAT`, exactly once and in read order.
- R7: A read cycle issued while the flag is low produces no `outValid` pulse.
- R8: One burst issues at most `FULL_WORDS` read cycles. A buffer holding more words is drained over several bursts, each one full.
- R9: `burstDone` is a single-cycle pulse. In that cycle `burstCount` equals the number of valid words delivered in the burst, for both short and full packets.
- R10: `start` has no effect while a burst is in progress: after the done pulse the block returns to idle with `csN` high, and it begins no second burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to request one read burst |
| bufFlag | input | 1 | Bridge buffer status, high = data available |
| busData | input | DATA_W | Parallel data bus from the bridge |
| csN | output | 1 | Chip select, active low |
| oeN | output | 1 | Output enable, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, held high |
| pktEndN | output | 1 | Packet-end strobe, held high |
| outValid | output | 1 | Received word valid |
| outData | output | DATA_W | Received word |
| burstCount | output | $clog2(FULL_WORDS+1) | Valid words captured in the current or last burst |
| burstDone | output | 1 | One-cycle end-of-burst pulse |

## Verification
Some strobe rules are checked by the embedded assertions on every cycle:
- output enable leads the read strobe, and the read strobe is gated by the delayed flag;
- the read strobe is released one cycle after the delayed flag reads empty;
- the read count never passes a full packet;
- chip select covers the other strobes;
- a valid output is always preceded by a read strobe `LAT` cycles earlier;
- the done pulse lasts one cycle.

Other behaviour can only be shown by the bench's scenarios, which run against a model of the bridge:
- the exact data values, their order and their arrival cycle;
- the number of over-reads after the flag drops;
- correct counts for short, single-word and back-to-back full packets;
- waiting on an empty buffer;
- ignoring `start` during a burst.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_FLAG,
    ST_ASSERT_OE,
    ST_READ,
    ST_DRAIN,
    ST_DONE
  } rdState_t;

  // strobes from control to datapath/bus, active-low bus pins plus a clear
  typedef struct packed {
    logic csN;
    logic oeN;
    logic rdN;
    logic clrCount;
  } busStrobes_t;

endpackage

// File: rtl/sfr_flag_delay.sv
module sfr_flag_delay #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flagRaw,
  output logic flagSeen
);

  logic [DEPTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else begin
      stage[0] <= flagRaw;
      for (int i = 1; i < DEPTH; i++) begin
        stage[i] <= stage[i-1];
      end
    end
  end

  assign flagSeen = stage[DEPTH-1];

endmodule

// File: rtl/sfr_control.sv
module sfr_control
  import sfr_pkg::*;
#(
  parameter int FULL_WORDS = 512,
  parameter int LAT        = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        flagSeen,
  output busStrobes_t strobes,
  output logic        burstDone
);

  localparam int ISS_W = $clog2(FULL_WORDS + 1);

  rdState_t         state, nextState;
  logic [ISS_W-1:0] issued;
  logic [1:0]       drainCnt;
  logic             lastRead;
  logic             drainEnd;

  assign lastRead = (issued == ISS_W'(FULL_WORDS - 1));
  assign drainEnd = (drainCnt == 2'(LAT - 2));

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:      if (start) nextState = ST_WAIT_FLAG;
      ST_WAIT_FLAG: if (flagSeen) nextState = ST_ASSERT_OE;
      ST_ASSERT_OE: nextState = ST_READ;
      ST_READ:      if (!flagSeen || lastRead) nextState = ST_DRAIN;
      ST_DRAIN:     if (drainEnd) nextState = ST_DONE;
      ST_DONE:      nextState = ST_IDLE;
      default:      nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      issued   <= '0;
      drainCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_ASSERT_OE) begin
        issued <= '0;
      end else if (state == ST_READ) begin
        issued <= issued + 1'b1;
      end
      if (state == ST_DRAIN) begin
        drainCnt <= drainCnt + 1'b1;
      end else begin
        drainCnt <= '0;
      end
    end
  end

  always_comb begin
    strobes = '{csN: 1'b1, oeN: 1'b1, rdN: 1'b1, clrCount: 1'b0};
    case (state)
      ST_WAIT_FLAG: strobes.csN = 1'b0;
      ST_ASSERT_OE: begin
        strobes.csN      = 1'b0;
        strobes.oeN      = 1'b0;
        strobes.clrCount = 1'b1;
      end
      ST_READ: begin
        strobes.csN = 1'b0;
        strobes.oeN = 1'b0;
        strobes.rdN = 1'b0;
      end
      ST_DRAIN: begin
        strobes.csN = 1'b0;
        strobes.oeN = 1'b0;
      end
      default: ;
    endcase
  end

  assign burstDone = (state == ST_DONE);

  assert_oe_leads_rd_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(strobes.rdN) |-> $past(!strobes.oeN))
    else $error("oeN not low before rdN fell");

  assert_rd_gated_by_flag_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(strobes.rdN) |-> $past(flagSeen, 2))
    else $error("rdN fell without delayed flag");

  assert_stop_on_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (!strobes.rdN && !flagSeen) |=> strobes.rdN)
    else $error("rdN held after empty seen");

  assert_full_cap_R8: assert property (@(posedge clk) disable iff (rst)
    !strobes.rdN |-> (issued < ISS_W'(FULL_WORDS)))
    else $error("read count beyond full packet");

  assert_cs_covers_R3: assert property (@(posedge clk) disable iff (rst)
    (!strobes.rdN || !strobes.oeN) |-> !strobes.csN)
    else $error("strobe active without chip select");

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    burstDone |=> !burstDone)
    else $error("done longer than one cycle");

endmodule

// File: rtl/sfr_datapath.sv
module sfr_datapath
  import sfr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LAT    = 2,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  busStrobes_t       strobes,
  input  logic              flagRaw,
  input  logic [DATA_W-1:0] busData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [CNT_W-1:0]  wordCount
);

  generate
    if (LAT < 2 || LAT > 3) begin : g_bad_lat
      $error("LAT must be 2 or 3");
    end
  endgenerate

  // marks read slots that will return a real word
  logic [LAT-2:0] slotPipe;
  logic           capture;

  assign capture = slotPipe[LAT-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      slotPipe  <= '0;
      outValid  <= 1'b0;
      outData   <= '0;
      wordCount <= '0;
    end else begin
      slotPipe[0] <= !strobes.rdN && flagRaw;
      for (int i = 1; i < LAT - 1; i++) begin
        slotPipe[i] <= slotPipe[i-1];
      end
      outValid <= capture;
      if (capture) begin
        outData <= busData;
      end
      if (strobes.clrCount) begin
        wordCount <= '0;
      end else if (capture) begin
        wordCount <= wordCount + 1'b1;
      end
    end
  end

  assert_valid_after_read_R6: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(!strobes.rdN, LAT))
    else $error("valid word without matching read");

  assert_no_clear_in_flight_R9: assert property (@(posedge clk) disable iff (rst)
    strobes.clrCount |-> !capture)
    else $error("count cleared with word in flight");

endmodule

// File: rtl/slave_fifo_reader.sv
module slave_fifo_reader
  import sfr_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FULL_WORDS = 512,
  parameter int LAT        = 2,
  parameter int FLAG_DLY   = 2,
  localparam int CNT_W     = $clog2(FULL_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bufFlag,
  input  logic [DATA_W-1:0] busData,
  output logic              csN,
  output logic              oeN,
  output logic              rdN,
  output logic              wrN,
  output logic              pktEndN,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [CNT_W-1:0]  burstCount,
  output logic              burstDone
);

  busStrobes_t strobes;
  logic        flagSeen;

  sfr_flag_delay #(.DEPTH(FLAG_DLY)) u_flagDelay (
    .clk      (clk),
    .rst      (rst),
    .flagRaw  (bufFlag),
    .flagSeen (flagSeen)
  );

  sfr_control #(.FULL_WORDS(FULL_WORDS), .LAT(LAT)) u_control (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .flagSeen  (flagSeen),
    .strobes   (strobes),
    .burstDone (burstDone)
  );

  sfr_datapath #(.DATA_W(DATA_W), .LAT(LAT), .CNT_W(CNT_W)) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .flagRaw   (bufFlag),
    .busData   (busData),
    .outValid  (outValid),
    .outData   (outData),
    .wordCount (burstCount)
  );

  assign csN     = strobes.csN;
  assign oeN     = strobes.oeN;
  assign rdN     = strobes.rdN;
  assign wrN     = 1'b1;
  assign pktEndN = 1'b1;

endmodule

// File: tb/slave_fifo_reader_bench.sv
module slave_fifo_reader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int FULL_WORDS = 16;
  localparam int LAT        = 3;
  localparam int FLAG_DLY   = 2;
  localparam int CNT_W      = $clog2(FULL_WORDS + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              bufFlag = 1'b0;
  logic [DATA_W-1:0] busData = 16'hDEAD;
  logic              csN, oeN, rdN, wrN, pktEndN, outValid, burstDone;
  logic [DATA_W-1:0] outData;
  logic [CNT_W-1:0]  burstCount;

  slave_fifo_reader #(
    .DATA_W(DATA_W), .FULL_WORDS(FULL_WORDS), .LAT(LAT), .FLAG_DLY(FLAG_DLY)
  ) u_slave_fifo_reader (
    .clk(clk), .rst(rst), .start(start), .bufFlag(bufFlag), .busData(busData),
    .csN(csN), .oeN(oeN), .rdN(rdN), .wrN(wrN), .pktEndN(pktEndN),
    .outValid(outValid), .outData(outData), .burstCount(burstCount),
    .burstDone(burstDone)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int avail  = 0;
  int nextWord = 0;
  int popsBurst = 0, rdCycles = 0, overReads = 0;
  int lastOver = 0, lastReads = 0, doneCount = 0;
  logic prevRdN = 1'b1, prevOeN = 1'b1, prevPrevOeN = 1'b1;
  logic [DATA_W-1:0] dline [LAT-1];
  logic [DATA_W-1:0] expData [$];
  int                expCyc  [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  initial for (int i = 0; i < LAT - 1; i++) dline[i] = 16'hDEAD;

  // bridge model and scoreboard monitor, both mid-cycle
  always @(negedge clk) begin
    logic [DATA_W-1:0] newWord;
    cyc++;
    if (rst) begin
      if (cyc > 1) begin
        check({csN, oeN, rdN, wrN, pktEndN} == 5'b11111, "R1 strobes", {csN, oeN, rdN, wrN, pktEndN}, 31);
        check(!outValid && !burstDone, "R1 outputs", {outValid, burstDone}, 0);
      end
    end else begin
      check(wrN && pktEndN, "R2", {wrN, pktEndN}, 3);
      if (!rdN || !oeN) check(!csN, "R3 cs covers", csN, 0);
      if (outValid) begin
        if (expData.size() == 0) begin
          check(1'b0, "R7 unexpected word", outData, -1);
        end else begin
          check(outData == expData[0], "R6 data", outData, expData[0]);
          check(cyc == expCyc[0], "R6 cycle", cyc, expCyc[0]);
          void'(expData.pop_front());
          void'(expCyc.pop_front());
        end
      end
      if (!rdN && prevRdN) begin
        check(!prevOeN && prevPrevOeN, "R4 oe lead", {prevPrevOeN, prevOeN}, 2);
      end
      if (burstDone) begin
        check(burstCount == popsBurst, "R9 count", burstCount, popsBurst);
        check(rdCycles <= FULL_WORDS, "R8 reads", rdCycles, FULL_WORDS);
        lastOver  = overReads;
        lastReads = rdCycles;
        doneCount++;
        popsBurst = 0; rdCycles = 0; overReads = 0;
      end
    end
    bufFlag = (avail > 0);
    newWord = 16'hDEAD;
    if (rdN === 1'b0) begin
      rdCycles++;
      if (avail > 0) begin
        newWord = 16'hA000 + 16'(nextWord);
        expData.push_back(newWord);
        expCyc.push_back(cyc + LAT);
        nextWord++;
        avail--;
        popsBurst++;
      end else begin
        overReads++;
      end
    end
    busData = dline[0];
    for (int i = 0; i < LAT - 2; i++) dline[i] = dline[i+1];
    dline[LAT-2] = newWord;
    prevPrevOeN = prevOeN;
    prevOeN = oeN;
    prevRdN = rdN;
  end

  task automatic pulseStart(input int addWords);
    @(posedge clk); #1;
    avail += addWords;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic waitDone(input int d0);
    while (doneCount == d0) @(posedge clk);
    #1;
  endtask

  task automatic runBurst(input int addWords, input int expCount, input int expOver, input string req);
    int d0;
    d0 = doneCount;
    pulseStart(addWords);
    check(csN == 1'b0, "R3 cs low", csN, 0);
    waitDone(d0);
    check(burstCount == expCount, req, burstCount, expCount);
    check(lastOver == expOver, "R5 over-reads", lastOver, expOver);
    repeat (3) @(posedge clk);
    #1;
    check(csN == 1'b1, "R3 idle", csN, 1);
    check(expData.size() == 0, "R6 all delivered", expData.size(), 0);
  endtask

  initial begin : main
    int d0;
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(csN && oeN && rdN, "R1 idle after reset", {csN, oeN, rdN}, 7);

    // short packet: flag drops mid-burst
    runBurst(5, 5, FLAG_DLY + 1, "R9 short packet");
    // more than a full packet: first burst capped
    runBurst(40, FULL_WORDS, 0, "R8 full packet");
    check(lastReads == FULL_WORDS, "R8 read cycles", lastReads, FULL_WORDS);
    runBurst(0, FULL_WORDS, 0, "R8 second full packet");
    runBurst(0, 8, FLAG_DLY + 1, "R9 remainder");
    runBurst(1, 1, FLAG_DLY + 1, "R9 single word");

    // start with empty buffer: must wait
    d0 = doneCount;
    pulseStart(0);
    repeat (8) @(posedge clk);
    #1;
    check(rdN && oeN, "R4 wait on empty", {rdN, oeN}, 3);
    check(!csN, "R3 cs during wait", csN, 0);
    avail += 3;
    waitDone(d0);
    check(burstCount == 3, "R9 late data", burstCount, 3);
    check(lastOver == FLAG_DLY + 1, "R7 over-reads dropped", lastOver, FLAG_DLY + 1);

    // start during a burst is ignored
    d0 = doneCount;
    pulseStart(20);
    repeat (6) @(posedge clk);
    #1;
    check(!rdN, "R10 in read", rdN, 0);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    waitDone(d0);
    check(burstCount == FULL_WORDS, "R10 burst count", burstCount, FULL_WORDS);
    repeat (6) @(posedge clk);
    #1;
    check(csN == 1'b1, "R10 back to idle", csN, 1);
    check(doneCount == d0 + 1, "R10 no extra burst", doneCount, d0 + 1);
    runBurst(0, 4, FLAG_DLY + 1, "R9 leftover");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule